// File: doc/BRIEF.md
# Synchronous Serial Absolute Position Transmitter

This block is the sensor-side output stage of an absolute position encoder that reports over a synchronous serial link. The receiver sends a burst of clock pulses on `ssiClk`. The line idles high. On the first falling edge of the burst, the block freezes a snapshot of the current position, the error flag and the coding choice. It then puts one bit of that snapshot on `sdo` for each rising edge, most significant bit first.

The word carries four things, sent in this order: one error bit first, then the position field in two's complement (optionally Gray coded), then one or more null bits. The total word length is chosen by `lenSel`. A word of n bits takes n+1 clock pulses. The extra rising edge pulls the data line low. The line stays low for a recovery interval of two measured clock periods, timed from the last falling edge, and then goes back high to show that the block is ready.

`ssiClk` is asynchronous to the system clock `clk`, so the block samples it through a synchronizer. It measures the receiver's clock period by counting `clk` cycles between falling edges.

Top module: `ssi_tx`

## Requirements
- R1: After reset, and whenever no burst or recovery interval is in progress, `sdo` is held high.
- R2: The transmitted word is captured at the first falling edge of a burst. Changes to `posIn` or `errIn` after that edge do not alter the bits of the burst in progress.
- R3: Each rising edge of `ssiClk` after the trigger puts the next bit on `sdo`, starting with the most significant bit. The word is sent in this order: error bit (1 = error), then the position field MSB to LSB, then the null bits, which are always 0.
- R4: `lenSel` picks the word length and its split:
  - 0 gives 24 bits, with a 22-bit position field and 1 null bit.
  - 1 gives 25 bits, with a 23-bit position field and 1 null bit.
  - 2 gives 26 bits, with a 24-bit position field and 1 null bit.
  - 3 gives 32 bits, with a 28-bit position field and 3 null bits.
- R5: When `grayEn` is 1, the position field is sent as Gray code: bit k equals binary bit k XOR binary bit k+1, and the field's top bit is unchanged. The error bit and the null bits are never Gray coded.
- R6: A negative `posIn` is sent in two's complement, truncated to the width of the position field.
- R7: The rising edge after the last data bit drives `sdo` low. `sdo` stays low until two measured clock periods have passed since the last falling edge, and then returns high.
- R8: Clock edges that arrive during the recovery interval are ignored. They neither start a burst nor lengthen the interval.
- R9: If no falling edge arrives within `TIMEOUT_CYC` system cycles during a burst, the block drops the burst and returns to idle with `sdo` high. The next falling edge starts a new burst.
- R10: `ssiClk` is synchronized to `clk`. `sdo` settles no later than three system clock cycles after the `ssiClk` edge that changes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low reset |
| ssiClk | input | 1 | Serial clock from the receiver, asynchronous, idles high |
| posIn | input | POS_W | Signed position value |
| errIn | input | 1 | Error flag sent in the word |
| grayEn | input | 1 | 1 selects Gray coding of the position field |
| lenSel | input | 2 | Word length select (see R4) |
| sdo | output | 1 | Serial data output |

## Verification
The synchronizer and the output register together delay `sdo` by three system cycles after each `ssiClk` edge. The bench therefore changes `ssiClk` away from the `clk` edge and compares `sdo` against its reference word exactly three cycles after every rising edge. At that point the bit is due and the next falling edge is still far off. Recovery timing is checked at two fixed offsets from the last falling edge: one well inside the two-period window, where `sdo` must still be low, and one past the window plus the synchronizer delay, where it must be high. The timeout is checked after the line has been held beyond `TIMEOUT_CYC` cycles.

// File: rtl/ssi_tx_pkg.sv
package ssi_tx_pkg;

  localparam int WORD_MAX = 32;

  typedef struct packed {
    logic load;
    logic shift;
    logic drvLow;
    logic drvHigh;
  } ssiStrobeT;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_MONO  = 2'd2
  } ssiStateT;

  function automatic logic [5:0] wordLen(input logic [1:0] sel);
    case (sel)
      2'd0:    return 6'd24;
      2'd1:    return 6'd25;
      2'd2:    return 6'd26;
      default: return 6'd32;
    endcase
  endfunction

  function automatic logic [5:0] nullLen(input logic [1:0] sel);
    return (sel == 2'd3) ? 6'd3 : 6'd1;
  endfunction

  function automatic logic [5:0] posLen(input logic [1:0] sel);
    return wordLen(sel) - nullLen(sel) - 6'd1;
  endfunction

endpackage

// File: rtl/ssi_tx_edge.sv
module ssi_tx_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic ssiClkIn,
  output logic rise,
  output logic fall
);
  logic [SYNC_STAGES:0] pipe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pipe <= '1;
    else       pipe <= {pipe[SYNC_STAGES-1:0], ssiClkIn};
  end

  assign rise = pipe[SYNC_STAGES-1] & ~pipe[SYNC_STAGES];
  assign fall = ~pipe[SYNC_STAGES-1] & pipe[SYNC_STAGES];

endmodule

// File: rtl/ssi_tx_ctrl.sv
module ssi_tx_ctrl
  import ssi_tx_pkg::*;
#(
  parameter int TIMEOUT_CYC = 2048
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      rise,
  input  logic      fall,
  input  logic [1:0] lenSel,
  output ssiStrobeT strb,
  output logic      busy
);
  localparam int CNT_W = $clog2(2 * TIMEOUT_CYC + 2);

  ssiStateT   state;
  logic [5:0] bitsLeft;
  logic [CNT_W-1:0] perCnt;
  logic [CNT_W-1:0] period;
  logic [CNT_W-1:0] monoCnt;
  logic timedOut;
  logic monoDone;

  assign timedOut = (perCnt >= CNT_W'(TIMEOUT_CYC));
  assign monoDone = (monoCnt >= {period[CNT_W-2:0], 1'b0});

  always_comb begin
    strb         = '0;
    strb.load    = (state == ST_IDLE) && fall;
    strb.shift   = (state == ST_SHIFT) && rise && (bitsLeft != 6'd0);
    strb.drvLow  = (state == ST_MONO) && rise && !monoDone;
    strb.drvHigh = ((state == ST_SHIFT) && timedOut && !fall) ||
                   ((state == ST_MONO) && monoDone);
  end

  assign busy = (state != ST_IDLE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      bitsLeft <= '0;
      perCnt   <= '0;
      period   <= '0;
      monoCnt  <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (fall) begin
            state    <= ST_SHIFT;
            bitsLeft <= wordLen(lenSel);
            perCnt   <= '0;
          end
        end
        ST_SHIFT: begin
          perCnt <= perCnt + 1'b1;
          if (strb.shift) bitsLeft <= bitsLeft - 6'd1;
          if (fall) begin
            period <= perCnt + 1'b1;
            perCnt <= '0;
            if (bitsLeft == 6'd0) begin
              state   <= ST_MONO;
              monoCnt <= '0;
            end
          end else if (timedOut) begin
            state <= ST_IDLE;
          end
        end
        ST_MONO: begin
          monoCnt <= monoCnt + 1'b1;
          if (monoDone) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  p_strobe_excl_r3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strb));

  p_mono_after_word_r3: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_MONO) |-> (bitsLeft == 6'd0));

  p_mono_length_r7: assert property (@(posedge clk) disable iff (!rstN)
    ((state == ST_IDLE) && ($past(state) == ST_MONO)) |->
      ($past(monoCnt) >= {$past(period[CNT_W-2:0]), 1'b0}));

  p_no_retrigger_r8: assert property (@(posedge clk) disable iff (!rstN)
    ((state == ST_MONO) && fall) |=> (state != ST_SHIFT));

  p_timeout_bound_r9: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SHIFT) |-> (perCnt <= CNT_W'(TIMEOUT_CYC)));

endmodule

// File: rtl/ssi_tx_datapath.sv
module ssi_tx_datapath
  import ssi_tx_pkg::*;
#(
  parameter int POS_W = 28
) (
  input  logic             clk,
  input  logic             rstN,
  input  ssiStrobeT        strb,
  input  logic [POS_W-1:0] posIn,
  input  logic             errIn,
  input  logic             grayEn,
  input  logic [1:0]       lenSel,
  output logic             sdo
);
  logic [WORD_MAX-1:0] holdWord;
  logic [WORD_MAX-1:0] nextWord;
  logic [WORD_MAX-1:0] posExt, fieldMask, fieldVal, codedVal, packedWord;
  logic [5:0] wl, pl, nl;

  always_comb begin
    wl         = wordLen(lenSel);
    pl         = posLen(lenSel);
    nl         = nullLen(lenSel);
    posExt     = WORD_MAX'(signed'(posIn));
    fieldMask  = (32'd1 << pl) - 32'd1;
    fieldVal   = posExt & fieldMask;
    codedVal   = grayEn ? (fieldVal ^ (fieldVal >> 1)) : fieldVal;
    packedWord = (WORD_MAX'(errIn) << (wl - 6'd1)) | (codedVal << nl);
    nextWord   = packedWord << (6'd32 - wl);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdWord <= '0;
      sdo      <= 1'b1;
    end else begin
      if (strb.load) begin
        holdWord <= nextWord;
      end else if (strb.shift) begin
        holdWord <= {holdWord[WORD_MAX-2:0], 1'b0};
        sdo      <= holdWord[WORD_MAX-1];
      end
      if (strb.drvLow)  sdo <= 1'b0;
      if (strb.drvHigh) sdo <= 1'b1;
    end
  end

  p_hold_stable_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.load && !strb.shift) |=> $stable(holdWord));

  p_shift_msb_r3: assert property (@(posedge clk) disable iff (!rstN)
    strb.shift |=> (sdo == $past(holdWord[WORD_MAX-1])));

endmodule

// File: rtl/ssi_tx.sv
module ssi_tx
  import ssi_tx_pkg::*;
#(
  parameter int POS_W       = 28,
  parameter int TIMEOUT_CYC = 2048,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             ssiClk,
  input  logic [POS_W-1:0] posIn,
  input  logic             errIn,
  input  logic             grayEn,
  input  logic [1:0]       lenSel,
  output logic             sdo
);
  logic      rise, fall, busy;
  ssiStrobeT strb;

  ssi_tx_edge #(.SYNC_STAGES(SYNC_STAGES)) edge_i (
    .clk(clk), .rstN(rstN), .ssiClkIn(ssiClk), .rise(rise), .fall(fall)
  );

  ssi_tx_ctrl #(.TIMEOUT_CYC(TIMEOUT_CYC)) ctrl_i (
    .clk(clk), .rstN(rstN), .rise(rise), .fall(fall), .lenSel(lenSel),
    .strb(strb), .busy(busy)
  );

  ssi_tx_datapath #(.POS_W(POS_W)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .posIn(posIn), .errIn(errIn),
    .grayEn(grayEn), .lenSel(lenSel), .sdo(sdo)
  );

  p_idle_high_r1: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && $past(!busy)) |-> sdo);

endmodule

// File: tb/ssi_tx_tb_top.sv
module ssi_tx_tb_top;
  localparam int H = 20;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ssiClk = 1'b1;
  logic [27:0] posIn = '0;
  logic        errIn = 1'b0;
  logic        grayEn = 1'b0;
  logic [1:0]  lenSel = 2'd3;
  logic        sdo;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  ssi_tx dut_i (
    .clk(clk), .rstN(rstN), .ssiClk(ssiClk), .posIn(posIn), .errIn(errIn),
    .grayEn(grayEn), .lenSel(lenSel), .sdo(sdo)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: sdo=%b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Behavioural reference: error bit, position field (opt. Gray), null zeros
  function automatic logic [31:0] refWord(input int pos, input bit err,
                                          input int sel, input bit gray);
    int pw;
    int idx;
    logic [31:0] w;
    pw = (sel == 0) ? 22 : (sel == 1) ? 23 : (sel == 2) ? 24 : 28;
    w = '0;
    idx = 31;
    w[idx] = err;
    idx--;
    for (int k = pw - 1; k >= 0; k--) begin
      bit b, bn;
      b  = ((pos >>> k) & 1) != 0;
      bn = (k == pw - 1) ? 1'b0 : (((pos >>> (k + 1)) & 1) != 0);
      w[idx] = gray ? (b ^ bn) : b;
      idx--;
    end
    return w;
  endfunction

  task automatic runBurst(input int pos, input bit err, input int sel,
                          input bit gray, input bit extraPulse);
    int n;
    logic [31:0] w;
    n = (sel == 0) ? 24 : (sel == 1) ? 25 : (sel == 2) ? 26 : 32;
    w = refWord(pos, err, sel, gray);
    posIn = pos[27:0]; errIn = err; lenSel = sel[1:0]; grayEn = gray;
    waitCyc(5);
    chk("R1 idle high before burst", sdo, 1'b1);
    for (int i = 0; i <= n; i++) begin
      ssiClk = 1'b0;
      waitCyc(H);
      if (i == 0) begin
        chk("R2 no output before first rising edge", sdo, 1'b1);
        posIn = ~posIn; errIn = ~errIn;   // R2: must not affect this burst
      end
      ssiClk = 1'b1;
      waitCyc(3);   // R10: settled three cycles after the edge
      if (i < n) chk($sformatf("R3/R4/R5/R6 bit %0d len %0d", i, n), sdo, w[31-i]);
      else       chk("R7 low after last rising edge", sdo, 1'b0);
      waitCyc(H - 3);
    end
    // now at last falling edge + 2H
    waitCyc(10);
    if (extraPulse) ssiClk = 1'b0;
    waitCyc(10);
    chk("R7 low inside recovery", sdo, 1'b0);
    if (extraPulse) ssiClk = 1'b1;
    waitCyc(10);
    chk("R7/R8 still low inside recovery", sdo, 1'b0);
    waitCyc(25);
    chk("R7/R8 high after recovery", sdo, 1'b1);
    waitCyc(20);
    chk("R1/R8 idle high, no retrigger", sdo, 1'b1);
  endtask

  initial begin
    waitCyc(5);
    chk("R1 reset state", sdo, 1'b1);
    rstN = 1'b1;
    waitCyc(10);
    chk("R1 idle after reset", sdo, 1'b1);

    runBurst(123456789, 1'b0, 3, 1'b0, 1'b0);
    runBurst(-5000,     1'b1, 0, 1'b1, 1'b0);
    runBurst(-1,        1'b0, 1, 1'b0, 1'b0);
    runBurst(32'h5A5A5A, 1'b1, 2, 1'b1, 1'b0);
    runBurst(-100000000, 1'b0, 3, 1'b1, 1'b1);   // R8 extra pulse in recovery

    // R9: stall a burst after one bit
    posIn = 28'h0000001; errIn = 1'b1; lenSel = 2'd0; grayEn = 1'b0;
    waitCyc(5);
    ssiClk = 1'b0; waitCyc(H);
    ssiClk = 1'b1; waitCyc(3);
    chk("R9 first bit before stall", sdo, 1'b1);
    waitCyc(100);
    chk("R9 holds bit before timeout", sdo, 1'b1);
    ssiClk = 1'b0; waitCyc(H);
    ssiClk = 1'b1; waitCyc(3);
    chk("R9 second bit before stall", sdo, 1'b0);
    waitCyc(2200);
    chk("R9 idle high after timeout", sdo, 1'b1);
    runBurst(2097151, 1'b0, 0, 1'b0, 1'b0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule